// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes from a host into asynchronous serial frames on a single line. A runtime mode word sets the frame: 5 to 8 data bits sent least-significant first, an optional even or odd parity bit, and a stop period of one, one and a half or two bit times. It also sets the bit time as 1, 16 or 64 periods of a separate transmit clock. The transmit clock is sampled in the system clock domain, and each of its rising edges becomes one timing tick.

A one-character holding register sits in front of the frame shifter. The host offers a byte with `wr_valid`. The byte is taken on any rising `clk` edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the host must keep `wr_valid` and `wr_data` stable, and no byte is lost or duplicated. `wr_ready` doubles as the ready flag: it is high only when the holding register is empty and transmission is enabled. `tx_empty` reports that no character is left anywhere in the block. A break command forces the line low without stopping the shifter.

Frames start on a tick. When the holding register is full at the tick that ends a stop period, the next start bit follows with no idle gap. The frame settings are captured when a character enters the shifter, so a mode change takes effect at the next frame.

Top module: `async_tx_serializer`

## Requirements
- R1: After reset, and whenever the block is empty with no break, `txd` is high.
- R2: A frame is a low start bit followed by the data bits, least-significant first. `mode_word[3:2]` sets the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused high bits of `wr_data` are not sent.
- R3: When `mode_word[4]` is 1, a parity bit follows the last data bit. When `mode_word[5]` is 1 the parity is even (data ones plus the parity bit give an even count); when it is 0 the parity is odd.
- R4: `mode_word[1:0]` sets the bit time in rising edges of `txc`: 01 gives 1, 10 gives 16 and 11 gives 64.
- R5: `mode_word[7:6]` sets the stop period: 01 gives 1 bit time, 10 gives 1.5 bit times and 11 gives 2. The 1.5 setting lasts 24 ticks at 16x, 96 ticks at 64x and 2 ticks at 1x. The value 00 is treated as 1 stop bit.
- R6: While `send_break` is 1, `txd` is low from the next clock onward. Shifting carries on underneath, so a frame in progress still completes.
- R7: `wr_ready` equals (holding register empty AND `tx_enable`). It drops in the cycle after a byte is accepted and rises again when the byte moves into the shifter.
- R8: `tx_empty` is high exactly when both the holding register and the shifter are empty. It falls in the cycle after a write is accepted, and it rises when the last stop period ends.
- R9: A character moves into the shifter only while `tx_enable` is 1. Clearing `tx_enable` lets the current frame finish, and any held byte then waits.
- R10: While `mode_word[1:0]` is 00, no frame starts and a held byte waits.
- R11: If a byte is held when a stop period ends, its start bit begins immediately after that stop period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txc | input | 1 | Transmit clock; each rising edge is one tick |
| mode_word | input | 8 | Frame format and baud factor |
| tx_enable | input | 1 | Allows characters to enter the shifter |
| send_break | input | 1 | Forces `txd` low |
| wr_valid | input | 1 | Host offers a byte |
| wr_data | input | 8 | Byte offered by the host |
| wr_ready | output | 1 | Holding register empty and transmit enabled |
| tx_empty | output | 1 | No character held or being shifted |
| txd | output | 1 | Serial output line |

## Verification
The assertions check the flag relations on every cycle. These are that ready implies enable and an empty, enabled block is ready; that an accepted write clears both ready and empty on the next cycle; that the line marks while empty and is low under break; and that a disabled, empty block stays empty. Frame content cannot be seen from a single cycle, so only the bench scenarios show it. That covers bit order, character length, parity sense, bit time per baud factor, every stop length including the 1.5 cases, and back-to-back frames. Finishing a frame after enable drops, holding off under the invalid baud code, and the time until empty rises are also covered only by the scenarios.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int MODE_W  = 8;
  localparam int MAX_DIV = 64;
  localparam int CNT_W   = $clog2(2 * MAX_DIV + 1);
  localparam int LEN_W   = $clog2(DATA_W);

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_START,
    SH_DATA,
    SH_PARITY,
    SH_STOP
  } sh_state_e;

  typedef struct packed {
    logic             baud_ok;
    logic [LEN_W-1:0] nbits_m1;
    logic             par_en;
    logic             par_even;
    logic [CNT_W-1:0] bit_ticks;
    logic [CNT_W-1:0] stop_ticks;
  } frame_cfg_t;

  // Turn the packed mode word into frame timing and format.
  function automatic frame_cfg_t decode_mode(input logic [MODE_W-1:0] mw);
    frame_cfg_t       c;
    logic [CNT_W-1:0] bt;
    case (mw[1:0])
      2'b10:   bt = CNT_W'(16);
      2'b11:   bt = CNT_W'(64);
      default: bt = CNT_W'(1);
    endcase
    c.baud_ok   = (mw[1:0] != 2'b00);
    c.nbits_m1  = LEN_W'(4) + LEN_W'(mw[3:2]);
    c.par_en    = mw[4];
    c.par_even  = mw[5];
    c.bit_ticks = bt;
    case (mw[7:6])
      2'b10:   c.stop_ticks = (bt == CNT_W'(1)) ? CNT_W'(2) : bt + (bt >> 1);
      2'b11:   c.stop_ticks = bt << 1;
      default: c.stop_ticks = bt;
    endcase
    return c;
  endfunction

  // Clear data bits above the selected character length.
  function automatic logic [DATA_W-1:0] mask_data(input logic [DATA_W-1:0] d,
                                                  input logic [LEN_W-1:0] n);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) begin
      m[i] = (i <= int'(n)) ? d[i] : 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/txc_tick_gen.sv
module txc_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txc,
  output logic tick
);
  // SYNC_STAGES synchroniser flops plus one history flop for edge detection.
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], txc};
  end

  assign tick = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              wr_ready,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data
);
  logic accept;

  assign wr_ready = ~hold_full & tx_enable;
  assign accept   = wr_valid & wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      if (accept) begin
        hold_full <= 1'b1;
        hold_data <= wr_data;
      end else if (take) begin
        hold_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_ok,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [MODE_W-1:0] mode_word,
  output logic              take,
  output logic              busy,
  output logic              line
);
  sh_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  bt_q;
  logic [CNT_W-1:0]  stop_q;
  logic              par_en_q;
  logic              par_q;
  logic [LEN_W-1:0]  left_q;
  logic [DATA_W-1:0] sh_q;

  frame_cfg_t        cfg_now;
  logic [DATA_W-1:0] data_m;
  logic              cnt_zero;
  logic              slot_free;

  assign cfg_now   = decode_mode(mode_word);
  assign data_m    = mask_data(hold_data, cfg_now.nbits_m1);
  assign cnt_zero  = (cnt_q == '0);
  assign slot_free = (state_q == SH_IDLE) || (state_q == SH_STOP && cnt_zero);
  assign take      = tick & load_ok & cfg_now.baud_ok & slot_free;
  assign busy      = (state_q != SH_IDLE);

  always_comb begin
    case (state_q)
      SH_START:  line = 1'b0;
      SH_DATA:   line = sh_q[0];
      SH_PARITY: line = par_q;
      default:   line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SH_IDLE;
      cnt_q    <= '0;
      bt_q     <= CNT_W'(1);
      stop_q   <= CNT_W'(1);
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
      left_q   <= '0;
      sh_q     <= '0;
    end else if (take) begin
      state_q  <= SH_START;
      cnt_q    <= cfg_now.bit_ticks - 1'b1;
      bt_q     <= cfg_now.bit_ticks;
      stop_q   <= cfg_now.stop_ticks;
      par_en_q <= cfg_now.par_en;
      par_q    <= cfg_now.par_even ? ^data_m : ~^data_m;
      left_q   <= cfg_now.nbits_m1;
      sh_q     <= data_m;
    end else if (tick) begin
      case (state_q)
        SH_START: begin
          if (cnt_zero) begin
            state_q <= SH_DATA;
            cnt_q   <= bt_q - 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SH_DATA: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (left_q != '0) begin
            sh_q   <= sh_q >> 1;
            left_q <= left_q - 1'b1;
            cnt_q  <= bt_q - 1'b1;
          end else if (par_en_q) begin
            state_q <= SH_PARITY;
            cnt_q   <= bt_q - 1'b1;
          end else begin
            state_q <= SH_STOP;
            cnt_q   <= stop_q - 1'b1;
          end
        end
        SH_PARITY: begin
          if (cnt_zero) begin
            state_q <= SH_STOP;
            cnt_q   <= stop_q - 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SH_STOP: begin
          if (cnt_zero) state_q <= SH_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/async_tx_serializer.sv
module async_tx_serializer
  import async_tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txc,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              tx_enable,
  input  logic              send_break,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              tx_empty,
  output logic              txd
);
  logic              tick;
  logic              take;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              busy;
  logic              line;

  txc_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .txc   (txc),
    .tick  (tick)
  );

  tx_hold_reg u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_enable (tx_enable),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .take      (take),
    .wr_ready  (wr_ready),
    .hold_full (hold_full),
    .hold_data (hold_data)
  );

  tx_frame_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load_ok   (hold_full & tx_enable),
    .hold_data (hold_data),
    .mode_word (mode_word),
    .take      (take),
    .busy      (busy),
    .line      (line)
  );

  assign tx_empty = ~hold_full & ~busy;

  // The output register keeps the line free of glitches; break overrides it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txd <= 1'b1;
    else        txd <= line & ~send_break;
  end
endmodule

// File: rtl/async_tx_checker.sv
module async_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_enable,
  input logic send_break,
  input logic wr_valid,
  input logic wr_ready,
  input logic tx_empty,
  input logic txd
);
  AST_READY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> tx_enable) else $error("ready without enable"); // R7
  AST_EMPTY_ENABLED_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && tx_enable) |-> wr_ready) else $error("empty but not ready"); // R7
  AST_WRITE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready) else $error("ready after write"); // R7
  AST_WRITE_DROPS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !tx_empty) else $error("empty after write"); // R8
  AST_IDLE_MARKING: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !send_break) |=> txd) else $error("idle line low"); // R1
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    send_break |=> !txd) else $error("break not low"); // R6
  AST_DISABLED_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !tx_enable) |=> tx_empty) else $error("load while disabled"); // R9
endmodule

bind async_tx_serializer async_tx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_enable  (tx_enable),
  .send_break (send_break),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .tx_empty   (tx_empty),
  .txd        (txd)
);

// File: tb/async_tx_serializer_tb_top.sv
module async_tx_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txc = 1'b0;
  logic [7:0] mode_word = 8'h4D;
  logic       tx_enable = 1'b1;
  logic       send_break = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready;
  logic       tx_empty;
  logic       txd;

  int n_checks = 0;
  int n_err = 0;

  always #10 clk = ~clk;  // 50 MHz

  // Transmit clock: period of four system clocks.
  initial begin
    forever begin
      repeat (2) @(negedge clk);
      txc = ~txc;
    end
  end

  async_tx_serializer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .txc        (txc),
    .mode_word  (mode_word),
    .tx_enable  (tx_enable),
    .send_break (send_break),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .wr_ready   (wr_ready),
    .tx_empty   (tx_empty),
    .txd        (txd)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [7:0] mw(input logic [1:0] stp, input bit ev, input bit pen,
                                    input logic [1:0] len, input logic [1:0] baud);
    return {stp, ev, pen, len, baud};
  endfunction

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!tx_empty) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // Receive one frame by sampling at mid-bit; 4 system clocks per tick.
  task automatic rx_frame(input int nbits, input bit pen, input bit ev, input int div,
                          input logic [7:0] data, input string tag);
    int   p;
    logic par;
    p   = 4 * div;
    par = ev ? 1'b0 : 1'b1;
    @(negedge txd);
    repeat (p / 2) @(negedge clk);
    chk(txd == 1'b0, {tag, " R2 start bit"}, txd, 0);
    for (int i = 0; i < nbits; i++) begin
      repeat (p) @(negedge clk);
      chk(txd == data[i], $sformatf("%s R2 R4 data bit %0d", tag, i), txd, data[i]);
      par = par ^ data[i];
    end
    if (pen) begin
      repeat (p) @(negedge clk);
      chk(txd == par, {tag, " R3 parity bit"}, txd, par);
    end
    repeat (p) @(negedge clk);
    chk(txd == 1'b1, {tag, " R5 stop bit"}, txd, 1);
    wait_idle();
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 line high after reset", txd, 1);
    chk(tx_empty == 1'b1, "R8 empty after reset", tx_empty, 1);
    chk(wr_ready == 1'b1, "R7 ready after reset", wr_ready, 1);
  endtask

  task automatic t_formats();
    mode_word = mw(2'b01, 0, 0, 2'b11, 2'b01);
    send(8'hA5);
    rx_frame(8, 0, 0, 1, 8'hA5, "R4 1x 8N1");
    mode_word = mw(2'b01, 1, 1, 2'b10, 2'b10);
    send(8'h5B);
    rx_frame(7, 1, 1, 16, 8'h5B, "R4 16x 7E1");
    mode_word = mw(2'b01, 0, 1, 2'b00, 2'b01);
    send(8'hF3);
    rx_frame(5, 1, 0, 1, 8'hF3, "R3 1x 5O1 masked");
    mode_word = mw(2'b01, 1, 1, 2'b01, 2'b11);
    send(8'h2C);
    rx_frame(6, 1, 1, 64, 8'h2C, "R4 64x 6E1");
    mode_word = mw(2'b01, 0, 1, 2'b11, 2'b01);
    send(8'h00);
    rx_frame(8, 1, 0, 1, 8'h00, "R3 1x 8O1 zero");
    chk(txd == 1'b1, "R1 line high between frames", txd, 1);
  endtask

  // Two zero 5-bit frames back to back: the high run between them is the stop period.
  task automatic measure_stop(input logic [1:0] stp, input logic [1:0] baud, input int exp_clks,
                              input string tag);
    int cnt;
    mode_word = mw(stp, 0, 0, 2'b00, baud);
    send(8'h00);
    send(8'h00);
    @(posedge txd);
    cnt = 0;
    @(negedge clk);
    while (txd) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == exp_clks, {tag, " R5 R11 stop length"}, cnt, exp_clks);
    wait_idle();
  endtask

  task automatic t_stops();
    measure_stop(2'b01, 2'b01, 4, "1 stop 1x");
    measure_stop(2'b10, 2'b01, 8, "1.5 stop 1x");
    measure_stop(2'b10, 2'b10, 96, "1.5 stop 16x");
    measure_stop(2'b11, 2'b10, 128, "2 stop 16x");
    measure_stop(2'b10, 2'b11, 384, "1.5 stop 64x");
    measure_stop(2'b00, 2'b10, 64, "invalid stop 16x");
  endtask

  task automatic t_break();
    int highs;
    mode_word = mw(2'b01, 0, 0, 2'b11, 2'b01);
    @(negedge clk);
    send_break = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd == 1'b0, "R6 break forces low when idle", txd, 0);
    send(8'hFF);
    highs = 0;
    repeat (60) begin
      @(negedge clk);
      if (txd) highs++;
    end
    chk(highs == 0, "R6 line low through frame", highs, 0);
    chk(tx_empty == 1'b1, "R6 frame completed under break", tx_empty, 1);
    send_break = 1'b0;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1, "R6 line released", txd, 1);
  endtask

  task automatic t_enable_gate();
    int bad;
    tx_enable = 1'b0;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = 8'h55;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (wr_ready) bad++;
    end
    wr_valid = 1'b0;
    chk(bad == 0, "R7 not ready while disabled", bad, 0);
    chk(tx_empty == 1'b1, "R9 no byte taken while disabled", tx_empty, 1);
    chk(txd == 1'b1, "R9 no frame while disabled", txd, 1);
    tx_enable = 1'b1;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R7 ready once enabled", wr_ready, 1);
  endtask

  task automatic t_enable_drop();
    int lows;
    mode_word = mw(2'b01, 0, 0, 2'b11, 2'b01);
    send(8'h00);
    send(8'hA5);
    tx_enable = 1'b0;
    lows = 0;
    while (!txd) begin
      lows++;
      @(negedge clk);
    end
    chk(lows == 36, "R9 current frame finishes", lows, 36);
    repeat (100) @(negedge clk);
    chk(txd == 1'b1, "R9 held byte not sent", txd, 1);
    chk(tx_empty == 1'b0, "R8 held byte keeps empty low", tx_empty, 0);
    chk(wr_ready == 1'b0, "R7 not ready while disabled and full", wr_ready, 0);
    tx_enable = 1'b1;
    rx_frame(8, 0, 0, 1, 8'hA5, "R9 resume");
  endtask

  task automatic t_baud_invalid();
    mode_word = mw(2'b01, 0, 0, 2'b11, 2'b00);
    send(8'h3C);
    repeat (100) @(negedge clk);
    chk(txd == 1'b1, "R10 no frame with baud 00", txd, 1);
    chk(tx_empty == 1'b0, "R10 byte still held", tx_empty, 0);
    chk(wr_ready == 1'b0, "R10 holding register stays full", wr_ready, 0);
    mode_word = mw(2'b01, 0, 0, 2'b11, 2'b01);
    rx_frame(8, 0, 0, 1, 8'h3C, "R10 released");
  endtask

  task automatic t_empty();
    int cnt;
    mode_word = mw(2'b01, 0, 0, 2'b11, 2'b10);
    send(8'h81);
    chk(tx_empty == 1'b0, "R8 empty falls after write", tx_empty, 0);
    chk(wr_ready == 1'b0, "R7 ready falls after write", wr_ready, 0);
    cnt = 0;
    while (!wr_ready && cnt < 20) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt <= 5, "R7 ready returns on load", cnt, 5);
    chk(tx_empty == 1'b0, "R8 empty low while shifting", tx_empty, 0);
    cnt = 0;
    while (!tx_empty && cnt < 2000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt >= 638 && cnt <= 642, "R8 empty rises after stop", cnt, 640);
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    t_reset();
    t_formats();
    t_stops();
    t_break();
    t_enable_gate();
    t_enable_drop();
    t_baud_invalid();
    t_empty();
    report();
  end
endmodule